// File: doc/BRIEF.md
# Four-Phase Handshake Sequencer Stage

This block is one stage of a control sequencer built from four-phase request/acknowledge handshakes. A stage waits for a request from the stage before it. It then raises its own action request toward the datapath and waits for the datapath to acknowledge. After that it passes control on by raising the acknowledge it returns to the previous stage. That acknowledge wire also serves as the request of the next stage, so a row of stages steps through a fixed series of datapath actions, one per stage.

The handshake runs on a clock. Both incoming wires are captured in flip-flops, and both outgoing wires come from flip-flops. A parameter selects one of two ordering disciplines. The strict variant passes control on only after the datapath handshake has fully returned to rest. The overlapped variant passes control on in the same cycle that it drops its action request, as soon as the datapath acknowledge arrives, so the next stage can start while the current action is still returning to rest. A second parameter makes the datapath acknowledge active-low, for acknowledge networks that signal completion with a low level.

Top module: `hs_seq_stage`

## Requirements
- R1: While the reset input is low, and afterwards until a request arrives, both outputs (`act_req_o`, `left_ack_o`) are 0.
- R2: From rest, `act_req_o` rises exactly two rising clock edges after `left_req_i` is first driven high.
- R3: `act_req_o` stays high until the datapath acknowledge is asserted. It falls exactly two clock edges after the acknowledge is first seen asserted.
- R4: Strict variant (`VARIANT` = 0): `left_ack_o` rises only after the acknowledge has been seen deasserted again, and it is never high while `act_req_o` is high.
- R5: Overlapped variant (`VARIANT` = 1): `left_ack_o` rises in the same cycle that `act_req_o` falls.
- R6: `left_ack_o` falls only after `left_req_i` has been seen low and the datapath acknowledge has been seen deasserted. The stage then returns to rest.
- R7: With `ACK_ACTIVE_LOW` = 1, a 0 on `act_ack_i` means asserted and a 1 means at rest. A stage set up this way completes its handshakes like one with an active-high acknowledge.
- R8: In a chain of strict stages, at most one action request is high at any time, and each stage raises its action request exactly once per start request.
- R9: In a chain of overlapped stages, the action request of a stage can be high while the acknowledge of the stage before it is still asserted.
- R10: `act_req_o` rises only when the acknowledge was deasserted two edges earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; its release is synchronised inside the block |
| left_req_i | input | 1 | Request from the previous stage, or the start request for the first stage |
| left_ack_o | output | 1 | Acknowledge to the previous stage; the next stage uses it as its request |
| act_req_o | output | 1 | Request that starts this stage's datapath action |
| act_ack_i | input | 1 | Completion acknowledge from the datapath; polarity set by `ACK_ACTIVE_LOW` |

## Verification
The assertions assume the stage is surrounded by a legal four-phase environment. The request from the left stays high until the acknowledge to the left rises, and stays low until that acknowledge falls. The datapath acknowledge changes only in response to a change of the action request. The bench keeps to these rules because every acknowledge comes from a responder that moves only after the matching request has moved. The only other stimulus is the start request of each chain, which is raised only when the chain is at rest and dropped only after its last stage has acknowledged. The responders wait a random number of cycles, and some runs force long delays before the acknowledge is released, so that overlap appears in the overlapped chain.

// File: rtl/hs_seq_pkg.sv
package hs_seq_pkg;

  typedef enum logic {
    VAR_STRICT  = 1'b0,
    VAR_OVERLAP = 1'b1
  } seq_variant_e;

  typedef enum logic [1:0] {
    ST_REST = 2'd0,
    ST_ACT  = 2'd1,
    ST_DRAIN = 2'd2,
    ST_PASS = 2'd3
  } seq_state_e;

endpackage

// File: rtl/hs_rst_sync.sv
module hs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/hs_in_sample.sv
module hs_in_sample #(
  parameter bit ACK_ACTIVE_LOW = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_pin,
  input  logic ack_pin,
  output logic req_q,
  output logic ack_q
);

  logic ack_norm;

  generate
    if (ACK_ACTIVE_LOW) begin : g_ack_low
      assign ack_norm = ~ack_pin;
    end else begin : g_ack_high
      assign ack_norm = ack_pin;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      req_q <= req_pin;
      ack_q <= ack_norm;
    end
  end

endmodule

// File: rtl/hs_seq_ctrl.sv
module hs_seq_ctrl
  import hs_seq_pkg::*;
#(
  parameter seq_variant_e VARIANT = VAR_STRICT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic ack,
  output logic act_req,
  output logic left_ack
);

  localparam seq_state_e AFTER_ACK = (VARIANT == VAR_OVERLAP) ? ST_PASS : ST_DRAIN;

  seq_state_e state_q, state_d;
  logic       state_en;
  logic       act_req_q, act_req_d;
  logic       left_ack_q, left_ack_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_REST:  if (req)          state_d = ST_ACT;
      ST_ACT:   if (ack)          state_d = AFTER_ACK;
      ST_DRAIN: if (!ack)         state_d = ST_PASS;
      ST_PASS:  if (!req && !ack) state_d = ST_REST;
      default:                    state_d = ST_REST;
    endcase
    state_en   = (state_d != state_q);
    act_req_d  = (state_d == ST_ACT);
    left_ack_d = (state_d == ST_PASS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_REST;
      act_req_q  <= 1'b0;
      left_ack_q <= 1'b0;
    end else if (state_en) begin
      state_q    <= state_d;
      act_req_q  <= act_req_d;
      left_ack_q <= left_ack_d;
    end
  end

  assign act_req  = act_req_q;
  assign left_ack = left_ack_q;

endmodule

// File: rtl/hs_seq_stage.sv
module hs_seq_stage
  import hs_seq_pkg::*;
#(
  parameter seq_variant_e VARIANT        = VAR_STRICT,
  parameter bit           ACK_ACTIVE_LOW = 1'b0,
  parameter int           RST_STAGES     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic left_req_i,
  output logic left_ack_o,
  output logic act_req_o,
  input  logic act_ack_i
);

  logic srst_n;
  logic req_s, ack_s;

  hs_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  hs_in_sample #(.ACK_ACTIVE_LOW(ACK_ACTIVE_LOW)) u_in (
    .clk     (clk),
    .rst_n   (srst_n),
    .req_pin (left_req_i),
    .ack_pin (act_ack_i),
    .req_q   (req_s),
    .ack_q   (ack_s)
  );

  hs_seq_ctrl #(.VARIANT(VARIANT)) u_ctrl (
    .clk      (clk),
    .rst_n    (srst_n),
    .req      (req_s),
    .ack      (ack_s),
    .act_req  (act_req_o),
    .left_ack (left_ack_o)
  );

endmodule

// File: rtl/hs_seq_stage_chk.sv
module hs_seq_stage_chk
  import hs_seq_pkg::*;
#(
  parameter seq_variant_e VARIANT        = VAR_STRICT,
  parameter bit           ACK_ACTIVE_LOW = 1'b0
) (
  input logic clk,
  input logic rst_n,
  input logic left_req_i,
  input logic left_ack_o,
  input logic act_req_o,
  input logic act_ack_i
);

  logic ack_on;
  assign ack_on = ACK_ACTIVE_LOW ? ~act_ack_i : act_ack_i;

  // R1: reset forces both outputs low
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (!act_req_o && !left_ack_o));

  assert_req_after_left_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_req_o) |-> $past(left_req_i, 2));

  assert_req_fall_after_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_req_o) |-> $past(ack_on, 2));

  assert_ack_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(left_ack_o) |-> ($past(!left_req_i, 2) && $past(!ack_on, 2)));

  assert_req_rise_ack_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_req_o) |-> $past(!ack_on, 2));

  generate
    if (VARIANT == VAR_OVERLAP) begin : g_overlap
      assert_overlap_handoff_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(left_ack_o) |-> $fell(act_req_o));
    end else begin : g_strict
      assert_strict_handoff_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(left_ack_o) |-> ($past(!ack_on, 2) && !act_req_o));
    end
  endgenerate

endmodule

bind hs_seq_stage hs_seq_stage_chk #(
  .VARIANT        (VARIANT),
  .ACK_ACTIVE_LOW (ACK_ACTIVE_LOW)
) u_chk (.*);

// File: tb/tb_hs_seq_stage.sv
module tb_hs_seq_stage;
  import hs_seq_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int N_RUNS     = 24;
  localparam int N_SLOW     = 4;
  localparam logic [2:0] T_LOW_MASK = 3'b010;

  logic clk;
  logic rst_n;
  logic start_s, start_t;
  logic [2:0] s_lr, s_la, s_or, s_oa, s_ack_on;
  logic [2:0] t_lr, t_la, t_or, t_oa, t_ack_on;
  logic slow_ack;
  int   n_checks, n_fail;
  bit   finished;

  assign s_lr = {s_la[1:0], start_s};
  assign t_lr = {t_la[1:0], start_t};
  assign s_oa = s_ack_on;
  assign t_oa = t_ack_on ^ T_LOW_MASK;

  hs_seq_stage #(.VARIANT(VAR_STRICT)) dut (
    .clk(clk), .rst_n(rst_n), .left_req_i(s_lr[0]), .left_ack_o(s_la[0]),
    .act_req_o(s_or[0]), .act_ack_i(s_oa[0]));
  hs_seq_stage #(.VARIANT(VAR_STRICT)) u_s1 (
    .clk(clk), .rst_n(rst_n), .left_req_i(s_lr[1]), .left_ack_o(s_la[1]),
    .act_req_o(s_or[1]), .act_ack_i(s_oa[1]));
  hs_seq_stage #(.VARIANT(VAR_STRICT)) u_s2 (
    .clk(clk), .rst_n(rst_n), .left_req_i(s_lr[2]), .left_ack_o(s_la[2]),
    .act_req_o(s_or[2]), .act_ack_i(s_oa[2]));
  hs_seq_stage #(.VARIANT(VAR_OVERLAP)) u_t0 (
    .clk(clk), .rst_n(rst_n), .left_req_i(t_lr[0]), .left_ack_o(t_la[0]),
    .act_req_o(t_or[0]), .act_ack_i(t_oa[0]));
  hs_seq_stage #(.VARIANT(VAR_OVERLAP), .ACK_ACTIVE_LOW(1'b1)) u_t1 (
    .clk(clk), .rst_n(rst_n), .left_req_i(t_lr[1]), .left_ack_o(t_la[1]),
    .act_req_o(t_or[1]), .act_ack_i(t_oa[1]));
  hs_seq_stage #(.VARIANT(VAR_OVERLAP)) u_t2 (
    .clk(clk), .rst_n(rst_n), .left_req_i(t_lr[2]), .left_ack_o(t_la[2]),
    .act_req_o(t_or[2]), .act_ack_i(t_oa[2]));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int expected_pulses();
    return 1;
  endfunction

  function automatic logic expected_req_after(input int edges);
    return (edges >= 2);
  endfunction

  function automatic int pick_delay(input logic slow);
    return slow ? 5 : int'($urandom_range(0, 4));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Acknowledge responders: each follows its request after a delay
  int s_cnt [3];
  int t_cnt [3];
  initial begin
    s_ack_on = '0;
    t_ack_on = '0;
    for (int k = 0; k < 3; k++) begin s_cnt[k] = 0; t_cnt[k] = 0; end
    forever begin
      @(negedge clk);
      for (int k = 0; k < 3; k++) begin
        if (s_or[k] != s_ack_on[k]) begin
          if (s_cnt[k] == 0) s_ack_on[k] = s_or[k];
          else s_cnt[k]--;
        end else s_cnt[k] = pick_delay(slow_ack);
        if (t_or[k] != t_ack_on[k]) begin
          if (t_cnt[k] == 0) t_ack_on[k] = t_or[k];
          else t_cnt[k]--;
        end else t_cnt[k] = pick_delay(slow_ack);
      end
    end
  end

  // Protocol monitor: reads values as the flip-flops capture them
  logic [2:0] s_or1, s_la1, s_lr1, s_ak1, s_lr2, s_ak2;
  logic [2:0] t_or1, t_la1, t_lr1, t_ak1, t_lr2, t_ak2;
  bit mon_on;
  int err_r3, err_r4, err_r5, err_r6, err_r8, err_r10;
  bit t_overlap_seen;
  int s_pulses [3];
  int t_pulses [3];

  always @(posedge clk) begin
    if (mon_on) begin
      if ($countones(s_or) > 1) err_r8++;
      for (int k = 0; k < 3; k++) begin
        if (s_or[k] && !s_or1[k]) begin
          s_pulses[k]++;
          if (!s_lr2[k] || s_ak2[k]) err_r10++;
        end
        if (t_or[k] && !t_or1[k]) begin
          t_pulses[k]++;
          if (!t_lr2[k] || t_ak2[k]) err_r10++;
        end
        if (!s_or[k] && s_or1[k] && !s_ak2[k]) err_r3++;
        if (!t_or[k] && t_or1[k] && !t_ak2[k]) err_r3++;
        if (s_la[k] && !s_la1[k] && (s_ak2[k] || s_or[k])) err_r4++;
        if (t_la[k] && !t_la1[k] && !(t_or1[k] && !t_or[k])) err_r5++;
        if (!s_la[k] && s_la1[k] && (s_lr2[k] || s_ak2[k])) err_r6++;
        if (!t_la[k] && t_la1[k] && (t_lr2[k] || t_ak2[k])) err_r6++;
      end
      for (int k = 0; k < 2; k++)
        if (t_or[k+1] && t_ack_on[k]) t_overlap_seen = 1'b1;
    end
    s_lr2 <= s_lr1; s_ak2 <= s_ak1; t_lr2 <= t_lr1; t_ak2 <= t_ak1;
    s_or1 <= s_or; s_la1 <= s_la; s_lr1 <= s_lr; s_ak1 <= s_ack_on;
    t_or1 <= t_or; t_la1 <= t_la; t_lr1 <= t_lr; t_ak1 <= t_ack_on;
  end

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_up();
  end

  task automatic do_run(input logic slow);
    int guard;
    slow_ack = slow;
    for (int k = 0; k < 3; k++) begin s_pulses[k] = 0; t_pulses[k] = 0; end
    @(negedge clk);
    start_s = 1'b1;
    start_t = 1'b1;
    // R2: exact rise cycle of the first action request in each chain
    for (int e = 1; e <= 2; e++) begin
      @(negedge clk);
      check(s_or[0] == expected_req_after(e), "R2 strict head", s_or[0], expected_req_after(e));
      check(t_or[0] == expected_req_after(e), "R2 overlap head", t_or[0], expected_req_after(e));
    end
    guard = 0;
    while (!(s_la[2] && t_la[2]) && guard < 300) begin @(negedge clk); guard++; end
    start_s = 1'b0;
    start_t = 1'b0;
    guard = 0;
    while ((s_la != 0 || t_la != 0 || s_or != 0 || t_or != 0 ||
            s_ack_on != 0 || t_ack_on != 0) && guard < 300) begin
      @(negedge clk); guard++;
    end
    repeat (3) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      check(s_pulses[k] == expected_pulses(), "R8 strict pulses per stage", s_pulses[k], expected_pulses());
      check(t_pulses[k] == expected_pulses(), "R7 overlap pulses (stage 1 active-low)", t_pulses[k], expected_pulses());
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    n_checks = 0; n_fail = 0; finished = 1'b0;
    mon_on = 1'b0; slow_ack = 1'b0; t_overlap_seen = 1'b0;
    err_r3 = 0; err_r4 = 0; err_r5 = 0; err_r6 = 0; err_r8 = 0; err_r10 = 0;
    start_s = 1'b0; start_t = 1'b0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    // R1: outputs low during reset
    check({s_or, s_la, t_or, t_la} == 12'h000, "R1 in reset", {s_or, s_la, t_or, t_la}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check({s_or, s_la, t_or, t_la} == 12'h000, "R1 after reset", {s_or, s_la, t_or, t_la}, 0);
    check(t_oa[1] == 1'b1, "R7 active-low ack rests high", t_oa[1], 1);
    mon_on = 1'b1;
    for (int r = 0; r < N_RUNS; r++) do_run(r < N_SLOW || r == N_RUNS - 1);
    mon_on = 1'b0;
    check(err_r3 == 0, "R3 request fell without ack", err_r3, 0);
    check(err_r4 == 0, "R4 strict handoff early", err_r4, 0);
    check(err_r5 == 0, "R5 overlap handoff not with request fall", err_r5, 0);
    check(err_r6 == 0, "R6 left ack released early", err_r6, 0);
    check(err_r8 == 0, "R8 strict requests overlapped", err_r8, 0);
    check(err_r10 == 0, "R10 request rose with ack asserted", err_r10, 0);
    check(t_overlap_seen, "R9 overlap chain never overlapped", t_overlap_seen, 1);
    finish_up();
  end

endmodule